// File: doc/BRIEF.md
# UART FIFO Controller with Receive Timeout

This block holds the receive and transmit byte queues of a 16550-style serial port and applies the FIFO control register to them. A receiver pushes bytes (or break events) into the receive queue and the host reads them back. The host writes bytes for transmission, and a transmitter pops them. One control write selects FIFO or single-byte mode, the receive trigger level, and flushes of either queue. Bit shifting on the line is done elsewhere. The block gets a per-bit-period tick and the frame-format bits of the line control register, and uses them to measure the receive character timeout.

The two queues treat overflow differently. A full receive queue refuses new bytes and flags an overrun. A full transmit queue drops its oldest byte so that the newest write fits. A write that changes the FIFO enable flushes both queues. In single-byte mode each side holds one byte, and a new receive byte replaces an unread one.

The timeout machine has three states. IDLE: no data, or FIFO mode is off. COUNT: counting bit ticks. FLAGGED: the timeout is pending. The transitions are:
- IDLE to COUNT on a receive push.
- COUNT to COUNT, with the counter restarted, on a push or a read that leaves data.
- COUNT to FLAGGED when 4 character times of ticks pass.
- FLAGGED to COUNT on a read that leaves data. A push in FLAGGED keeps it FLAGGED.
- Any state to IDLE when the queue becomes empty, FIFO mode is off, or the receive queue is flushed.

Top module: `uart_fifo_ctrl`

## Requirements
- R1: After reset both counts are 0, `data_ready`, `overrun`, `brk_flag` and `timeout_pend` are 0, `thr_empty` is 1, FIFO mode is off and the trigger level is 1.
- R2: A control write keeps bit 0 (FIFO enable), bits 7:6 (trigger code) and bit 3. Bits 1 and 2 act only as flush commands and are not stored. Trigger codes 00, 01, 10 and 11 give levels 1, 4, 8 and 14. In FIFO mode `rx_level_hit` is 1 when the receive count is at least the level. Otherwise it equals `data_ready`.
- R3: Control bit 1 empties the receive queue and clears `brk_flag` and `timeout_pend`. Control bit 2 empties the transmit queue, which sets `thr_empty`.
- R4: A control write whose bit 0 differs from the current enable flushes both queues, whatever bits 1 and 2 hold.
- R5: In FIFO mode, a byte that arrives at a receive queue holding 16 bytes is dropped and sets `overrun`.
- R6: A host write to a full transmit queue discards the oldest byte, then appends the new one. Full means 16 bytes in FIFO mode and 1 byte otherwise.
- R7: In single-byte mode, a byte that arrives while `data_ready` is 1 replaces the held byte and sets `overrun`.
- R8: A received break pushes a 0x00 byte and sets both `brk_flag` and `data_ready`.
- R9: `rd_data` shows the oldest receive byte, or 0 when the queue is empty, and a host read removes it. `data_ready` falls when the last byte is read. `status_rd` clears `overrun` and `brk_flag`, but a set in the same cycle wins.
- R10: In FIFO mode with data held, `timeout_pend` rises after 4 character times of `bit_tick` with no push and no read. A push or read restarts the count. A read clears the pending flag. A push does not clear it.
- R11: One character time is this many bit ticks: 1 start bit + (fmt[1:0]+5) data bits + fmt[3] parity bit + (fmt[2] ? 2 : 1) stop bits.
- R12: In one cycle, a host read is applied before a receive push, and a transmit pop before a host write. In a control-write cycle, pushes, reads, writes and pops are ignored and the timer holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_push | input | 1 | Receiver delivers a byte or break |
| rx_data | input | 8 | Received byte |
| rx_break | input | 1 | The push is a break event |
| host_rd | input | 1 | Host reads the receive buffer |
| rd_data | output | 8 | Oldest receive byte, 0 when empty |
| host_wr | input | 1 | Host writes the holding register |
| wr_data | input | 8 | Byte to transmit |
| tx_pop | input | 1 | Transmitter takes the oldest byte |
| tx_data | output | 8 | Oldest transmit byte, 0 when empty |
| fmt | input | 4 | Frame format: [1:0] data length, [2] stop bits, [3] parity |
| bit_tick | input | 1 | One pulse per bit period |
| fcr_wr | input | 1 | FIFO control write strobe |
| fcr_data | input | 8 | FIFO control value |
| status_rd | input | 1 | Host reads line status (clears overrun and break) |
| data_ready | output | 1 | Receive data held |
| overrun | output | 1 | Sticky receive overrun |
| brk_flag | output | 1 | Sticky break seen |
| thr_empty | output | 1 | Transmit side empty |
| rx_count | output | 5 | Receive queue occupancy |
| tx_count | output | 5 | Transmit queue occupancy |
| timeout_pend | output | 1 | Character timeout pending |
| rx_level_hit | output | 1 | Receive trigger level reached |
| fifo_en | output | 1 | FIFO mode active |

## Verification
Every queue pointer and counter shows at the ports within one cycle. A wrong pointer gives a wrong `rd_data` or `tx_data` on the next read or pop. A wrong count gives a wrong `rx_count`, `tx_count` or `rx_level_hit` on the very next clock. A timer fault shows only as `timeout_pend` rising a tick early or late, so the bench counts ticks exactly for two frame formats, each at its boundary cycle. A behavioural queue model is compared with every output on each clock, so a corrupted flag is reported in the cycle after it goes wrong.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;

    typedef enum logic [1:0] {
        TMO_IDLE,
        TMO_COUNT,
        TMO_FLAGGED
    } tmo_state_t;

    // bit ticks in one character: start + data + parity + stop
    function automatic logic [3:0] frame_bits(input logic [3:0] f);
        logic [3:0] n;
        n = 4'd1 + {2'b00, f[1:0]} + 4'd5 + {3'b000, f[3]} + (f[2] ? 4'd2 : 4'd1);
        return n;
    endfunction

    function automatic logic [4:0] trig_level(input logic [1:0] code);
        logic [4:0] l;
        unique case (code)
            2'b00:   l = 5'd1;
            2'b01:   l = 5'd4;
            2'b10:   l = 5'd8;
            default: l = 5'd14;
        endcase
        return l;
    endfunction

endpackage

// File: rtl/uart_byte_fifo.sv
module uart_byte_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 8,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic          pop,
    input  logic [W-1:0]  din,
    output logic [W-1:0]  head,
    output logic [CW-1:0] count
);
    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] rd_ptr, wr_ptr;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            count <= count + CW'(push) - CW'(pop);
        end
    end

    always_ff @(posedge clk) begin
        if (rst_n && !flush && push) mem[wr_ptr] <= din;
    end

    assign head = mem[rd_ptr];

    // R5: the caller never pushes into a full store without popping
    a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && !flush) |-> (count < CW'(DEPTH)));
    // R9: the caller never pops an empty store
    a_r9_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !flush) |-> (count != '0));

endmodule

// File: rtl/uart_rx_timeout.sv
module uart_rx_timeout
    import uart_fifo_pkg::*;
#(
    parameter int TMO_CHARS = 4,
    localparam int TCW      = $clog2(TMO_CHARS * 12 + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic       flush,
    input  logic       hold,
    input  logic       push_evt,
    input  logic       read_evt,
    input  logic       have_data_next,
    input  logic       have_data,
    input  logic       bit_tick,
    input  logic [3:0] fmt,
    output logic       pend
);
    tmo_state_t     st, st_n;
    logic [TCW-1:0] cnt, cnt_n;
    logic [TCW-1:0] limit;

    assign limit = TCW'(TMO_CHARS) * TCW'(frame_bits(fmt));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= TMO_IDLE;
            cnt <= '0;
        end else begin
            st  <= st_n;
            cnt <= cnt_n;
        end
    end

    always_comb begin
        st_n  = st;
        cnt_n = cnt;
        if (flush) begin
            st_n  = TMO_IDLE;
            cnt_n = '0;
        end else if (hold) begin
            st_n  = st;
        end else if (!enable || !have_data_next) begin
            st_n  = TMO_IDLE;
            cnt_n = '0;
        end else if (read_evt) begin
            st_n  = TMO_COUNT;
            cnt_n = '0;
        end else if (push_evt) begin
            cnt_n = '0;
            if (st != TMO_FLAGGED) st_n = TMO_COUNT;
        end else begin
            unique case (st)
                TMO_IDLE: st_n = TMO_IDLE;
                TMO_COUNT: begin
                    if (bit_tick) begin
                        if (cnt >= limit - TCW'(1)) begin
                            st_n  = TMO_FLAGGED;
                            cnt_n = '0;
                        end else begin
                            cnt_n = cnt + TCW'(1);
                        end
                    end
                end
                TMO_FLAGGED: st_n = TMO_FLAGGED;
                default: st_n = TMO_IDLE;
            endcase
        end
    end

    always_comb begin
        pend = (st == TMO_FLAGGED);
    end

    // R10: a pending timeout always has data behind it
    a_r10_pend_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
        pend |-> have_data);
    // R10: a host read drops the pending flag
    a_r10_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (read_evt && !hold && !flush) |=> !pend);

endmodule

// File: rtl/uart_fifo_ctrl.sv
module uart_fifo_ctrl
    import uart_fifo_pkg::*;
#(
    parameter int DEPTH     = 16,
    parameter int TMO_CHARS = 4,
    localparam int CW       = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_push,
    input  logic [7:0]    rx_data,
    input  logic          rx_break,
    input  logic          host_rd,
    output logic [7:0]    rd_data,
    input  logic          host_wr,
    input  logic [7:0]    wr_data,
    input  logic          tx_pop,
    output logic [7:0]    tx_data,
    input  logic [3:0]    fmt,
    input  logic          bit_tick,
    input  logic          fcr_wr,
    input  logic [7:0]    fcr_data,
    input  logic          status_rd,
    output logic          data_ready,
    output logic          overrun,
    output logic          brk_flag,
    output logic          thr_empty,
    output logic [CW-1:0] rx_count,
    output logic [CW-1:0] tx_count,
    output logic          timeout_pend,
    output logic          rx_level_hit,
    output logic          fifo_en
);
    localparam logic [7:0] FCR_KEEP = 8'hC9;

    logic [7:0]    fcr_q;
    logic          toggle, rx_flush, tx_flush, busy;
    logic [CW-1:0] cap, rx_left, tx_left, rx_cnt_next;
    logic          rd_pop, rx_full_after, rx_push_en, rx_pop_en, rx_replace;
    logic          tx_rm, tx_full_after, tx_push_en, tx_pop_en;
    logic          ovr_set, brk_set;
    logic [7:0]    rx_in, rx_head, tx_head;
    logic [4:0]    level;

    assign fifo_en  = fcr_q[0];
    assign busy     = fcr_wr;
    assign toggle   = fcr_data[0] ^ fcr_q[0];
    assign rx_flush = fcr_wr & (fcr_data[1] | toggle);
    assign tx_flush = fcr_wr & (fcr_data[2] | toggle);
    assign cap      = fifo_en ? CW'(DEPTH) : CW'(1);

    // receive side: read first, then push
    always_comb begin
        rd_pop        = !busy && host_rd && (rx_count != '0);
        rx_left       = rx_count - CW'(rd_pop);
        rx_full_after = (rx_left >= cap);
        rx_in         = rx_break ? 8'h00 : rx_data;
        rx_replace    = !busy && rx_push && rx_full_after && !fifo_en;
        rx_push_en    = (!busy && rx_push && !rx_full_after) || rx_replace;
        rx_pop_en     = rd_pop || rx_replace;
        ovr_set       = !busy && rx_push && rx_full_after;
        brk_set       = !busy && rx_push && rx_break;
        rx_cnt_next   = rx_flush ? '0 : rx_count + CW'(rx_push_en) - CW'(rx_pop_en);
    end

    // transmit side: pop first, then write (oldest dropped when full)
    always_comb begin
        tx_rm         = !busy && tx_pop && (tx_count != '0);
        tx_left       = tx_count - CW'(tx_rm);
        tx_full_after = (tx_left >= cap);
        tx_push_en    = !busy && host_wr;
        tx_pop_en     = tx_rm || (tx_push_en && tx_full_after);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fcr_q    <= '0;
            overrun  <= 1'b0;
            brk_flag <= 1'b0;
        end else begin
            if (fcr_wr) fcr_q <= fcr_data & FCR_KEEP;
            overrun  <= (overrun & ~status_rd) | ovr_set;
            brk_flag <= rx_flush ? 1'b0 : ((brk_flag & ~status_rd) | brk_set);
        end
    end

    uart_byte_fifo #(.DEPTH(DEPTH), .W(8)) u_rx_q (
        .clk(clk), .rst_n(rst_n), .flush(rx_flush),
        .push(rx_push_en), .pop(rx_pop_en), .din(rx_in),
        .head(rx_head), .count(rx_count)
    );

    uart_byte_fifo #(.DEPTH(DEPTH), .W(8)) u_tx_q (
        .clk(clk), .rst_n(rst_n), .flush(tx_flush),
        .push(tx_push_en), .pop(tx_pop_en), .din(wr_data),
        .head(tx_head), .count(tx_count)
    );

    uart_rx_timeout #(.TMO_CHARS(TMO_CHARS)) u_tmo (
        .clk(clk), .rst_n(rst_n), .enable(fifo_en),
        .flush(rx_flush), .hold(busy && !rx_flush),
        .push_evt(!busy && rx_push), .read_evt(!busy && host_rd),
        .have_data_next(rx_cnt_next != '0), .have_data(rx_count != '0),
        .bit_tick(bit_tick), .fmt(fmt), .pend(timeout_pend)
    );

    assign level        = trig_level(fcr_q[7:6]);
    assign data_ready   = (rx_count != '0);
    assign thr_empty    = (tx_count == '0);
    assign rx_level_hit = fifo_en ? (rx_count >= CW'(level)) : data_ready;
    assign rd_data      = data_ready ? rx_head : 8'h00;
    assign tx_data      = thr_empty ? 8'h00 : tx_head;

    // R3: a receive flush leaves nothing behind
    a_r3_rx_flush: assert property (@(posedge clk) disable iff (!rst_n)
        (fcr_wr && fcr_data[1]) |=> (rx_count == '0 && !brk_flag && !timeout_pend));
    // R4: changing the enable empties both sides
    a_r4_toggle_flush: assert property (@(posedge clk) disable iff (!rst_n)
        (fcr_wr && (fcr_data[0] != fifo_en)) |=> (rx_count == '0 && thr_empty));
    // R5: full receive queue refuses the byte and flags overrun
    a_r5_rx_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (!fcr_wr && fifo_en && rx_count == CW'(DEPTH) && rx_push && !host_rd)
        |=> (rx_count == CW'(DEPTH) && overrun));
    // R6: full transmit queue stays full on a write
    a_r6_tx_full: assert property (@(posedge clk) disable iff (!rst_n)
        (!fcr_wr && fifo_en && tx_count == CW'(DEPTH) && host_wr && !tx_pop)
        |=> (tx_count == CW'(DEPTH)));
    // R8: break raises both flags
    a_r8_break: assert property (@(posedge clk) disable iff (!rst_n)
        (!fcr_wr && rx_push && rx_break) |=> (brk_flag && data_ready));

endmodule

// File: tb/test_uart_fifo_ctrl.sv
module test_uart_fifo_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_push = 0, rx_break = 0, host_rd = 0, host_wr = 0, tx_pop = 0;
    logic       bit_tick = 0, fcr_wr = 0, status_rd = 0;
    logic [7:0] rx_data = 0, wr_data = 0, fcr_data = 0;
    logic [3:0] fmt = 0;
    logic [7:0] rd_data, tx_data;
    logic       data_ready, overrun, brk_flag, thr_empty, timeout_pend, rx_level_hit, fifo_en;
    logic [4:0] rx_count, tx_count;

    int checks = 0, fails = 0;
    string cur_req = "R1";
    bit done = 0;

    always #4 clk = ~clk;

    uart_fifo_ctrl i_uart_fifo_ctrl (
        .clk(clk), .rst_n(rst_n), .rx_push(rx_push), .rx_data(rx_data), .rx_break(rx_break),
        .host_rd(host_rd), .rd_data(rd_data), .host_wr(host_wr), .wr_data(wr_data),
        .tx_pop(tx_pop), .tx_data(tx_data), .fmt(fmt), .bit_tick(bit_tick),
        .fcr_wr(fcr_wr), .fcr_data(fcr_data), .status_rd(status_rd),
        .data_ready(data_ready), .overrun(overrun), .brk_flag(brk_flag), .thr_empty(thr_empty),
        .rx_count(rx_count), .tx_count(tx_count), .timeout_pend(timeout_pend),
        .rx_level_hit(rx_level_hit), .fifo_en(fifo_en)
    );

    // reference model
    logic [7:0] rxq[$];
    logic [7:0] txq[$];
    bit m_en, m_ovr, m_brk;
    int m_lvl, m_st, m_cnt;

    function automatic int lvl_of(input logic [1:0] c);
        return (c == 0) ? 1 : (c == 1) ? 4 : (c == 2) ? 8 : 14;
    endfunction

    function automatic int fbits(input logic [3:0] f);
        return 1 + (f[1:0] + 5) + f[3] + (f[2] ? 2 : 1);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            rxq.delete(); txq.delete();
            m_en = 0; m_ovr = 0; m_brk = 0; m_lvl = 1; m_st = 0; m_cnt = 0;
        end else if (fcr_wr) begin
            bit tog;
            tog = (fcr_data[0] != m_en);
            if (status_rd) begin m_ovr = 0; m_brk = 0; end
            if (fcr_data[1] || tog) begin rxq.delete(); m_brk = 0; m_st = 0; m_cnt = 0; end
            if (fcr_data[2] || tog) txq.delete();
            m_en = fcr_data[0];
            m_lvl = lvl_of(fcr_data[7:6]);
        end else begin
            int cap;
            logic [7:0] b;
            cap = m_en ? 16 : 1;
            if (status_rd) begin m_ovr = 0; m_brk = 0; end
            if (host_rd && rxq.size() > 0) void'(rxq.pop_front());
            if (rx_push) begin
                b = rx_break ? 8'h00 : rx_data;
                if (rx_break) m_brk = 1;
                if (rxq.size() < cap) rxq.push_back(b);
                else begin
                    m_ovr = 1;
                    if (!m_en) begin void'(rxq.pop_front()); rxq.push_back(b); end
                end
            end
            if (tx_pop && txq.size() > 0) void'(txq.pop_front());
            if (host_wr) begin
                if (txq.size() >= cap) void'(txq.pop_front());
                txq.push_back(wr_data);
            end
            if (!m_en || rxq.size() == 0) begin m_st = 0; m_cnt = 0; end
            else if (host_rd) begin m_st = 1; m_cnt = 0; end
            else if (rx_push) begin m_cnt = 0; if (m_st != 2) m_st = 1; end
            else if (m_st == 1 && bit_tick) begin
                if (m_cnt >= 4 * fbits(fmt) - 1) begin m_st = 2; m_cnt = 0; end
                else m_cnt++;
            end
        end
    end

    task automatic chk(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual %0d expected %0d", cur_req, what, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("rx_count", rx_count, rxq.size());
            chk("tx_count", tx_count, txq.size());
            chk("data_ready", data_ready, rxq.size() != 0);
            chk("thr_empty", thr_empty, txq.size() == 0);
            chk("overrun", overrun, m_ovr);
            chk("brk_flag", brk_flag, m_brk);
            chk("timeout_pend", timeout_pend, m_st == 2);
            chk("fifo_en", fifo_en, m_en);
            chk("rx_level_hit", rx_level_hit, m_en ? (rxq.size() >= m_lvl) : (rxq.size() != 0));
            chk("rd_data", rd_data, rxq.size() ? rxq[0] : 0);
            chk("tx_data", tx_data, txq.size() ? txq[0] : 0);
        end
    end

    task automatic clr();
        rx_push = 0; rx_break = 0; host_rd = 0; host_wr = 0; tx_pop = 0;
        fcr_wr = 0; status_rd = 0;
    endtask
    task automatic cyc(); @(negedge clk); clr(); endtask
    task automatic push(input logic [7:0] b, input bit brk = 0);
        rx_push = 1; rx_data = b; rx_break = brk; cyc();
    endtask
    task automatic rd(); host_rd = 1; cyc(); endtask
    task automatic wr(input logic [7:0] b); host_wr = 1; wr_data = b; cyc(); endtask
    task automatic pop(); tx_pop = 1; cyc(); endtask
    task automatic fcr(input logic [7:0] v); fcr_wr = 1; fcr_data = v; cyc(); endtask
    task automatic srd(); status_rd = 1; cyc(); endtask
    task automatic idle(input int n); for (int i = 0; i < n; i++) cyc(); endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual 1 expected 0");
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        cur_req = "R1";
        @(negedge clk);
        chk("reset thr_empty", thr_empty, 1);
        chk("reset rx_count", rx_count, 0);
        idle(2);

        cur_req = "R2";
        fcr(8'h01); push(8'h11);
        chk("level1 hit", rx_level_hit, 1);
        fcr(8'h47);                       // level 4, flushes both, stays enabled
        push(8'h21); push(8'h22); push(8'h23);
        chk("level4 at 3", rx_level_hit, 0);
        push(8'h24);
        chk("level4 at 4", rx_level_hit, 1);
        fcr(8'h81);
        chk("level8 at 4", rx_level_hit, 0);
        for (int i = 0; i < 4; i++) push(8'h30 + 8'(i));
        chk("level8 at 8", rx_level_hit, 1);
        fcr(8'hC1);
        for (int i = 0; i < 6; i++) push(8'h40 + 8'(i));
        chk("level14 at 14", rx_level_hit, 1);

        cur_req = "R5";
        push(8'h50); push(8'h51);
        chk("rx count full", rx_count, 16);
        push(8'h52);
        chk("rx dropped", rx_count, 16);
        chk("overrun set", overrun, 1);

        cur_req = "R9";
        srd();
        chk("overrun cleared", overrun, 0);
        chk("head byte", rd_data, 8'h21);
        for (int i = 0; i < 16; i++) rd();
        chk("empty after drain", data_ready, 0);
        rd();
        chk("empty read data", rd_data, 0);

        cur_req = "R6";
        for (int i = 0; i < 17; i++) wr(8'h60 + 8'(i));
        chk("tx oldest gone", tx_data, 8'h61);
        for (int i = 0; i < 16; i++) pop();
        chk("tx empty", thr_empty, 1);

        cur_req = "R3";
        push(8'h71); push(8'h72, 1); wr(8'h73);
        fcr(8'hC3);
        chk("rx flushed", rx_count, 0);
        chk("brk cleared", brk_flag, 0);
        chk("tx untouched", tx_count, 1);
        fcr(8'hC5);
        chk("tx flushed", thr_empty, 1);

        cur_req = "R8";
        push(8'h99, 1);
        chk("break byte", rd_data, 0);
        chk("break flag", brk_flag, 1);
        chk("break dr", data_ready, 1);
        srd();

        cur_req = "R4";
        wr(8'h81); push(8'h82);
        fcr(8'h00);
        chk("toggle rx", rx_count, 0);
        chk("toggle tx", tx_count, 0);

        cur_req = "R7";
        push(8'hA1); push(8'hA2);
        chk("single overwrite", rd_data, 8'hA2);
        chk("single overrun", overrun, 1);
        srd(); rd();
        wr(8'hB1); wr(8'hB2);
        chk("single tx replace", tx_data, 8'hB2);
        pop();

        cur_req = "R10";
        fcr(8'h01); fmt = 4'h0; bit_tick = 1;
        push(8'hC1); push(8'hC2);
        idle(27);
        chk("no timeout yet", timeout_pend, 0);
        idle(1);
        chk("timeout at 28", timeout_pend, 1);
        push(8'hC3);
        chk("push keeps pend", timeout_pend, 1);
        rd();
        chk("read clears pend", timeout_pend, 0);
        idle(30);

        cur_req = "R11";
        rd(); rd();
        fmt = 4'hF; push(8'hD1);
        idle(47);
        chk("12-bit frame early", timeout_pend, 0);
        idle(1);
        chk("12-bit frame on time", timeout_pend, 1);
        bit_tick = 0; rd();

        cur_req = "R12";
        fcr(8'hC1);
        for (int i = 0; i < 16; i++) push(8'hE0 + 8'(i));
        host_rd = 1; rx_push = 1; rx_data = 8'hEF; cyc();
        chk("read then push", rx_count, 16);
        chk("read then push ovr", overrun, 0);
        for (int i = 0; i < 16; i++) wr(8'hF0 + 8'(i));
        tx_pop = 1; host_wr = 1; wr_data = 8'hFF; cyc();
        chk("pop then write", tx_data, 8'hF1);
        fcr_wr = 1; fcr_data = 8'hC1; rx_push = 1; host_rd = 1; tx_pop = 1; cyc();
        chk("fcr cycle ignores ops", rx_count, 16);
        idle(3);
        finish_up();
    end
endmodule